// File: doc/BRIEF.md
# Running Disparity Error Monitor with Interrupt Status

This block watches a received serial bit stream while a message is in progress. It keeps a signed difference between the ones and the zeros seen since the message began. When ones lead by the ones limit, or zeros lead by the zeros limit, it sets a sticky error flag. The two limits differ. Long runs cannot wrap the difference, because it is clamped at each limit.

The error flag is one of four event sources held in a byte-wide status register. The other three sources are a qualified change on a user pin, a transmit-queue overflow pulse and a transmit-queue underflow pulse. A second byte-wide register holds one enable bit per source. One interrupt line is raised when any source is both set and enabled. A host reaches both registers through a single-cycle write strobe, a register select and a combinational read bus. Writing a 1 to a status bit clears that bit.

Top module: `disparity_irq_unit`

## Requirements
- R1: Within a message, the bit that first makes the count of ones exceed the count of zeros by ONES_LIMIT (default 25) sets status bit 2 at the clock edge that accepts that bit. An excess of one less leaves the bit clear.
- R2: Within a message, the bit that first makes the count of zeros exceed the count of ones by ZEROS_LIMIT (default 27) sets status bit 2. An excess of one less leaves the bit clear.
- R3: A message-start strobe resets the difference to zero, and a bit accepted in the same cycle counts from zero. A bit is counted only when both msg_active and bit_valid are high.
- R4: The difference is clamped between +ONES_LIMIT and -ZEROS_LIMIT. After 40 ones, 51 zeros leave status bit 2 clear and the 52nd zero sets it.
- R5: While rl_check_off is high, no excess of either polarity sets status bit 2.
- R6: Writing to the status register (host_sel=0) clears each bit written as 1 and leaves each bit written as 0 unchanged. The status bits are: bit 3 pin event, bit 2 run-length error, bit 1 overflow, bit 0 underflow.
- R7: When a source event and a write-1-to-clear reach the same status bit in the same cycle, the bit ends up set.
- R8: irq_out is high exactly when some status bit and the unmask bit at the same position (host_sel=1) are both 1.
- R9: After reset the status register reads 0x04, the unmask register reads 0x00 and irq_out is low.
- R10: user_pin_mode selects the pin event that sets status bit 3: 0 none, 1 rising, 2 falling, 3 either edge.
- R11: A txq_overflow pulse sets status bit 1. A txq_underflow pulse sets status bit 0.
- R12: Bits 7:4 of both registers always read 0. Writes to those bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_start | input | 1 | One-cycle strobe at the start of a message |
| msg_active | input | 1 | High while a message is being received |
| bit_valid | input | 1 | A received bit is present on bit_data |
| bit_data | input | 1 | Received bit value |
| rl_check_off | input | 1 | Suppresses run-length error detection |
| user_pin | input | 1 | Synchronous user pin |
| user_pin_mode | input | 2 | Pin event select |
| txq_overflow | input | 1 | Transmit queue overflow pulse |
| txq_underflow | input | 1 | Transmit queue underflow pulse |
| host_wr | input | 1 | Register write strobe |
| host_sel | input | 1 | 0 selects status, 1 selects unmask |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data of the selected register |
| irq_out | output | 1 | Summary interrupt |

## Verification
The running difference is hidden, so an error in it only shows as status bit 2 setting one bit early, one bit late or not at all. The threshold checks therefore place the decisive bit exactly at each limit and read the register on the next cycle. A clamp that fails to hold, or a counter that wraps, only shows after a long run in one direction followed by a run the other way. The saturation test exposes this within about a hundred bits. A wrong status or mask bit shows on host_rdata and irq_out in the cycle after the event or write that caused it.

// File: rtl/rdm_pkg.sv
package rdm_pkg;
   localparam int NSRC    = 4;
   localparam int IDX_UNF = 0;
   localparam int IDX_OVF = 1;
   localparam int IDX_RL  = 2;
   localparam int IDX_PIN = 3;

   typedef enum logic [1:0] {
      PIN_OFF  = 2'd0,
      PIN_RISE = 2'd1,
      PIN_FALL = 2'd2,
      PIN_ANY  = 2'd3
   } pin_mode_e;
endpackage

// File: rtl/rdm_disparity_tracker.sv
module rdm_disparity_tracker #(
   parameter int ONES_LIMIT  = 25,
   parameter int ZEROS_LIMIT = 27
) (
   input  logic clk,
   input  logic rst_n,
   input  logic msg_start,
   input  logic msg_active,
   input  logic bit_valid,
   input  logic bit_data,
   input  logic check_off,
   output logic err_evt
);
   localparam int MAXL = (ONES_LIMIT > ZEROS_LIMIT) ? ONES_LIMIT : ZEROS_LIMIT;
   localparam int CW   = $clog2(MAXL + 1) + 1;
   localparam logic signed [CW-1:0] HI    = CW'(ONES_LIMIT);
   localparam logic signed [CW-1:0] LO    = -CW'(ZEROS_LIMIT);
   localparam logic signed [CW-1:0] ONE_S = CW'(1);

   logic signed [CW-1:0] diff_q, base, stepped, diff_d;
   logic take;

   if (ONES_LIMIT < 1)  $error("ONES_LIMIT must be at least 1");
   if (ZEROS_LIMIT < 1) $error("ZEROS_LIMIT must be at least 1");

   always_comb begin
      base = msg_start ? '0 : diff_q;
      take = msg_active && bit_valid;
      if (bit_data) stepped = (base == HI) ? HI : base + ONE_S;
      else          stepped = (base == LO) ? LO : base - ONE_S;
      diff_d  = take ? stepped : base;
      err_evt = take && !check_off && ((stepped == HI) || (stepped == LO));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) diff_q <= '0;
      else        diff_q <= diff_d;
   end
endmodule

// File: rtl/rdm_pin_event.sv
module rdm_pin_event
   import rdm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin,
   input  logic [1:0] mode,
   output logic       evt
);
   logic prev_q, rise, fall;
   pin_mode_e m;

   always_comb begin
      m    = pin_mode_e'(mode);
      rise = pin && !prev_q;
      fall = !pin && prev_q;
      unique case (m)
         PIN_OFF:  evt = 1'b0;
         PIN_RISE: evt = rise;
         PIN_FALL: evt = fall;
         PIN_ANY:  evt = rise || fall;
         default:  evt = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pin;
   end
endmodule

// File: rtl/rdm_irq_regs.sv
module rdm_irq_regs #(
   parameter int DW   = 8,
   parameter int NSRC = 4,
   parameter logic [NSRC-1:0] STAT_RESET = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] set_vec,
   input  logic            host_wr,
   input  logic            host_sel,
   input  logic [NSRC-1:0] host_wbits,
   output logic [NSRC-1:0] status,
   output logic [NSRC-1:0] unmask,
   output logic [DW-1:0]   rdata,
   output logic            irq
);
   localparam int PADW = DW - NSRC;

   logic [NSRC-1:0] clr_vec;
   logic            mask_we;

   if (PADW < 1) $error("DW must exceed NSRC");

   assign clr_vec = (host_wr && !host_sel) ? host_wbits : '0;
   assign mask_we = host_wr && host_sel;

   for (genvar g = 0; g < NSRC; g++) begin : g_cell
      logic cell_q;
      always_ff @(posedge clk) begin
         if (!rst_n)          cell_q <= STAT_RESET[g];
         else if (set_vec[g]) cell_q <= 1'b1;
         else if (clr_vec[g]) cell_q <= 1'b0;
      end
      assign status[g] = cell_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       unmask <= '0;
      else if (mask_we) unmask <= host_wbits;
   end

   assign rdata = {{PADW{1'b0}}, (host_sel ? unmask : status)};
   assign irq   = |(status & unmask);
endmodule

// File: rtl/disparity_irq_unit.sv
module disparity_irq_unit
   import rdm_pkg::*;
#(
   parameter int DW          = 8,
   parameter int ONES_LIMIT  = 25,
   parameter int ZEROS_LIMIT = 27
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          msg_start,
   input  logic          msg_active,
   input  logic          bit_valid,
   input  logic          bit_data,
   input  logic          rl_check_off,
   input  logic          user_pin,
   input  logic [1:0]    user_pin_mode,
   input  logic          txq_overflow,
   input  logic          txq_underflow,
   input  logic          host_wr,
   input  logic          host_sel,
   input  logic [DW-1:0] host_wdata,
   output logic [DW-1:0] host_rdata,
   output logic          irq_out
);
   localparam logic [NSRC-1:0] STAT_RESET = NSRC'(1) << IDX_RL;

   logic            rl_evt, pin_evt;
   logic [NSRC-1:0] set_vec, stat_bits, mask_bits;
   wire             unused_wbits = ^host_wdata[DW-1:NSRC];

   if (DW <= NSRC) $error("DW too small for the status sources");

   rdm_disparity_tracker #(.ONES_LIMIT(ONES_LIMIT), .ZEROS_LIMIT(ZEROS_LIMIT)) u_track (
      .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .msg_active(msg_active),
      .bit_valid(bit_valid), .bit_data(bit_data), .check_off(rl_check_off),
      .err_evt(rl_evt)
   );

   rdm_pin_event u_pin (
      .clk(clk), .rst_n(rst_n), .pin(user_pin), .mode(user_pin_mode), .evt(pin_evt)
   );

   always_comb begin
      set_vec          = '0;
      set_vec[IDX_UNF] = txq_underflow;
      set_vec[IDX_OVF] = txq_overflow;
      set_vec[IDX_RL]  = rl_evt;
      set_vec[IDX_PIN] = pin_evt;
   end

   rdm_irq_regs #(.DW(DW), .NSRC(NSRC), .STAT_RESET(STAT_RESET)) u_regs (
      .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .host_wr(host_wr),
      .host_sel(host_sel), .host_wbits(host_wdata[NSRC-1:0]),
      .status(stat_bits), .unmask(mask_bits), .rdata(host_rdata), .irq(irq_out)
   );
endmodule

// File: rtl/disparity_irq_checker.sv
module disparity_irq_checker #(
   parameter int DW   = 8,
   parameter int NSRC = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            txq_overflow,
   input logic            txq_underflow,
   input logic            rl_check_off,
   input logic            host_wr,
   input logic            host_sel,
   input logic [DW-1:0]   host_wdata,
   input logic [DW-1:0]   host_rdata,
   input logic [NSRC-1:0] stat_bits,
   input logic [NSRC-1:0] mask_bits,
   input logic            irq_out
);
   logic stat_wr;
   assign stat_wr = host_wr && !host_sel;

   assert_ovf_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      txq_overflow |=> stat_bits[1]);

   assert_unf_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
      txq_underflow |=> stat_bits[0]);

   assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (txq_underflow && stat_wr && host_wdata[0]) |=> stat_bits[0]);

   assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && host_wdata[0] && !txq_underflow) |=> !stat_bits[0]);

   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_bits[2] && !(stat_wr && host_wdata[2])) |=> stat_bits[2]);

   assert_disable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_bits[2]) |-> !$past(rl_check_off));

   assert_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (txq_overflow && mask_bits[1] && !(host_wr && host_sel)) |=> irq_out);

   assert_reserved_R12: assert property (@(posedge clk) disable iff (!rst_n)
      host_rdata[DW-1:NSRC] == '0);
endmodule

bind disparity_irq_unit disparity_irq_checker #(.DW(DW), .NSRC(rdm_pkg::NSRC)) u_chk (
   .clk(clk), .rst_n(rst_n), .txq_overflow(txq_overflow), .txq_underflow(txq_underflow),
   .rl_check_off(rl_check_off), .host_wr(host_wr), .host_sel(host_sel),
   .host_wdata(host_wdata), .host_rdata(host_rdata), .stat_bits(stat_bits),
   .mask_bits(mask_bits), .irq_out(irq_out)
);

// File: tb/disparity_irq_unit_tb.sv
module disparity_irq_unit_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       msg_start = 0, msg_active = 0, bit_valid = 0, bit_data = 0;
   logic       rl_check_off = 0, user_pin = 0;
   logic [1:0] user_pin_mode = 2'd0;
   logic       txq_overflow = 0, txq_underflow = 0;
   logic       host_wr = 0, host_sel = 0;
   logic [7:0] host_wdata = 8'h00;
   logic [7:0] host_rdata;
   logic       irq_out;
   int         total = 0, bad = 0;
   bit         done = 0;

   always #10 clk = ~clk;

   disparity_irq_unit u_dut (
      .clk(clk), .rst_n(rst_n), .msg_start(msg_start), .msg_active(msg_active),
      .bit_valid(bit_valid), .bit_data(bit_data), .rl_check_off(rl_check_off),
      .user_pin(user_pin), .user_pin_mode(user_pin_mode),
      .txq_overflow(txq_overflow), .txq_underflow(txq_underflow),
      .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
      .host_rdata(host_rdata), .irq_out(irq_out)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
      end
   endtask

   task automatic step_bit(input logic b);
      @(negedge clk); bit_valid = 1'b1; bit_data = b;
      @(negedge clk); bit_valid = 1'b0;
   endtask

   task automatic bits(input int n, input logic b);
      for (int i = 0; i < n; i++) step_bit(b);
   endtask

   task automatic start_msg();
      @(negedge clk); msg_start = 1'b1;
      @(negedge clk); msg_start = 1'b0;
   endtask

   task automatic wr(input logic s, input logic [7:0] d);
      @(negedge clk); host_sel = s; host_wdata = d; host_wr = 1'b1;
      @(negedge clk); host_wr = 1'b0; host_wdata = 8'h00;
   endtask

   task automatic rd(input logic s, output logic [7:0] d);
      @(negedge clk); host_sel = s; #1; d = host_rdata;
   endtask

   task automatic pulse(input logic ovf, input logic unf);
      @(negedge clk); txq_overflow = ovf; txq_underflow = unf;
      @(negedge clk); txq_overflow = 1'b0; txq_underflow = 1'b0;
   endtask

   task automatic set_pin(input logic v);
      @(negedge clk); user_pin = v;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd(1'b0, v); chk("R9 status reset", v, 8'h04);
      rd(1'b1, v); chk("R9 unmask reset", v, 8'h00);
      chk("R9 irq reset", {7'd0, irq_out}, 8'h00);
   endtask

   task automatic t_ones();
      logic [7:0] v;
      wr(1'b0, 8'h0F); msg_active = 1'b1; start_msg();
      bits(24, 1'b1); rd(1'b0, v); chk("R1 excess 24 ones", v, 8'h00);
      bits(1, 1'b1);  rd(1'b0, v); chk("R1 excess 25 ones", v, 8'h04);
   endtask

   task automatic t_zeros();
      logic [7:0] v;
      wr(1'b0, 8'h04); start_msg();
      bits(26, 1'b0); rd(1'b0, v); chk("R2 excess 26 zeros", v, 8'h00);
      bits(1, 1'b0);  rd(1'b0, v); chk("R2 excess 27 zeros", v, 8'h04);
   endtask

   task automatic t_restart();
      logic [7:0] v;
      wr(1'b0, 8'h04); start_msg(); bits(24, 1'b1);
      start_msg(); bits(24, 1'b1);
      rd(1'b0, v); chk("R3 restart resets difference", v, 8'h00);
      msg_active = 1'b0; bits(10, 1'b1); msg_active = 1'b1;
      rd(1'b0, v); chk("R3 inactive bits ignored", v, 8'h00);
      bits(1, 1'b1); rd(1'b0, v); chk("R3 count resumes", v, 8'h04);
   endtask

   task automatic t_saturate();
      logic [7:0] v;
      wr(1'b0, 8'h04); start_msg(); bits(40, 1'b1);
      rd(1'b0, v); chk("R4 long ones run flags", v, 8'h04);
      wr(1'b0, 8'h04);
      bits(51, 1'b0); rd(1'b0, v); chk("R4 clamp 51 zeros", v, 8'h00);
      bits(1, 1'b0);  rd(1'b0, v); chk("R4 clamp 52 zeros", v, 8'h04);
   endtask

   task automatic t_disable();
      logic [7:0] v;
      wr(1'b0, 8'h04); rl_check_off = 1'b1;
      start_msg(); bits(30, 1'b1);
      rd(1'b0, v); chk("R5 ones ignored when off", v, 8'h00);
      start_msg(); bits(30, 1'b0);
      rd(1'b0, v); chk("R5 zeros ignored when off", v, 8'h00);
      rl_check_off = 1'b0; start_msg(); msg_active = 1'b0;
   endtask

   task automatic t_w1c();
      logic [7:0] v;
      pulse(1'b1, 1'b1); rd(1'b0, v); chk("R11 overflow and underflow set", v, 8'h03);
      wr(1'b0, 8'h01); rd(1'b0, v); chk("R6 clear bit 0 only", v, 8'h02);
      wr(1'b0, 8'h00); rd(1'b0, v); chk("R6 zero write keeps", v, 8'h02);
      wr(1'b0, 8'h02); rd(1'b0, v); chk("R6 clear bit 1", v, 8'h00);
   endtask

   task automatic t_collide();
      logic [7:0] v;
      @(negedge clk); txq_overflow = 1'b1; host_sel = 1'b0; host_wdata = 8'h02; host_wr = 1'b1;
      @(negedge clk); txq_overflow = 1'b0; host_wr = 1'b0; host_wdata = 8'h00;
      rd(1'b0, v); chk("R7 set beats clear", v, 8'h02);
      wr(1'b0, 8'h02);
   endtask

   task automatic t_irq();
      logic [7:0] v;
      wr(1'b1, 8'h02); rd(1'b1, v); chk("R8 unmask readback", v, 8'h02);
      chk("R8 irq low with empty status", {7'd0, irq_out}, 8'h00);
      pulse(1'b0, 1'b1); #1; chk("R8 masked source no irq", {7'd0, irq_out}, 8'h00);
      pulse(1'b1, 1'b0); #1; chk("R8 unmasked source irq", {7'd0, irq_out}, 8'h01);
      wr(1'b0, 8'h02); #1; chk("R8 irq drops on clear", {7'd0, irq_out}, 8'h00);
      wr(1'b1, 8'h00); wr(1'b0, 8'h01);
   endtask

   task automatic t_reserved();
      logic [7:0] v;
      wr(1'b1, 8'hF5); rd(1'b1, v); chk("R12 unmask reserved bits", v, 8'h05);
      wr(1'b1, 8'h00);
      pulse(1'b1, 1'b0); wr(1'b0, 8'hF0);
      rd(1'b0, v); chk("R12 reserved clear ignored", v, 8'h02);
      wr(1'b0, 8'h02);
   endtask

   task automatic t_pin();
      logic [7:0] v;
      user_pin_mode = 2'd0; set_pin(1'b1); set_pin(1'b0);
      rd(1'b0, v); chk("R10 mode off", v, 8'h00);
      user_pin_mode = 2'd1; set_pin(1'b1);
      rd(1'b0, v); chk("R10 rising seen", v, 8'h08);
      wr(1'b0, 8'h08); set_pin(1'b0);
      rd(1'b0, v); chk("R10 falling ignored in rise mode", v, 8'h00);
      user_pin_mode = 2'd2; set_pin(1'b1);
      rd(1'b0, v); chk("R10 rising ignored in fall mode", v, 8'h00);
      set_pin(1'b0);
      rd(1'b0, v); chk("R10 falling seen", v, 8'h08);
      wr(1'b0, 8'h08); user_pin_mode = 2'd3; set_pin(1'b1);
      rd(1'b0, v); chk("R10 any mode rising", v, 8'h08);
      wr(1'b0, 8'h08); set_pin(1'b0);
      rd(1'b0, v); chk("R10 any mode falling", v, 8'h08);
      wr(1'b0, 8'h08);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ones();
      t_zeros();
      t_restart();
      t_saturate();
      t_disable();
      t_w1c();
      t_collide();
      t_irq();
      t_reserved();
      t_pin();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule